// File: doc/BRIEF.md
# Two-phase fork and join controller

This block is the control and data glue for a pipeline that branches and merges, with every handshake carried as a two-phase toggle. Each toggle of a request or acknowledge marks one data item, and no signal returns to zero. The fork path takes one upstream stage's word and request and presents both to two downstream stages. It acknowledges upstream only after both downstream stages have taken the previous item. The join path waits until both upstream stages have raised a new request. It then forwards the two words, concatenated, as one item. The single downstream acknowledge goes back to both sources.

Both paths combine their inputs with a Muller C-element. The element copies its inputs once they all agree and otherwise keeps its old value. It drives a capture register that acts as the latch controller of the stage. The fork merges acknowledges and the join merges requests. The design is clocked, with the C-element output held in a flop. That flop costs one cycle at the merge point, and the capture register costs one more. The data is bundled with its request. A source must hold its word steady from its request toggle until the block's acknowledge toggles back to match that request.

Top module: `fj_ctrl`

## Requirements
- R1: While `rst_n` is low, every request, acknowledge and data output is 0 from the first clock edge on.
- R2: `fk_out_req` toggles only on an edge where both `fk_out_ack_a` and `fk_out_ack_b` already equal the current `fk_out_req`. One destination on its own never lets the fork move on.
- R3: The fork takes a new item when `fk_in_req` differs from `fk_out_req` and the merged acknowledge has caught up. On that edge `fk_out_req` takes the value of `fk_in_req` and `fk_out_data` takes `fk_in_data`. `fk_in_ack` always equals `fk_out_req`, so it toggles once per item.
- R4: `fk_out_data` does not change on any edge where `fk_out_req` does not toggle.
- R5: `jn_out_req` toggles only after both `jn_in_req_a` and `jn_in_req_b` have toggled to the new phase. Because the merged request is registered, this happens at the earliest on the second edge after the later of the two request toggles.
- R6: When the join takes an item, `jn_out_data` becomes `{jn_in_data_a, jn_in_data_b}`. Source A fills the upper DW bits and source B the lower DW bits.
- R7: `jn_in_ack` is one output shared by both sources and always equals `jn_out_req`. The join takes no new item while `jn_out_ack` differs from `jn_out_req`.
- R8: `jn_out_data` does not change on any edge where `jn_out_req` does not toggle.
- R9: While the inputs of a merge disagree, the merged value holds. These inputs are the two fork acknowledges or the two join requests. Skew between branches therefore delays the merged event and never creates an extra one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fk_in_req | input | 1 | Fork upstream request toggle |
| fk_in_data | input | DW | Fork upstream data word |
| fk_in_ack | output | 1 | Fork acknowledge to upstream |
| fk_out_req | output | 1 | Request toggle shared by both fork destinations |
| fk_out_data | output | DW | Data word shared by both fork destinations |
| fk_out_ack_a | input | 1 | Acknowledge from fork destination A |
| fk_out_ack_b | input | 1 | Acknowledge from fork destination B |
| jn_in_req_a | input | 1 | Request toggle from join source A |
| jn_in_data_a | input | DW | Data word from join source A |
| jn_in_req_b | input | 1 | Request toggle from join source B |
| jn_in_data_b | input | DW | Data word from join source B |
| jn_in_ack | output | 1 | Acknowledge shared by both join sources |
| jn_out_req | output | 1 | Merged request toggle to the join destination |
| jn_out_data | output | 2*DW | Concatenated join data word |
| jn_out_ack | input | 1 | Acknowledge from the join destination |

## Verification
Two events can fall on the same edge in each stage. One is the merge completing: the second fork acknowledge arrives, or the second join request arrives. The other is the stage's upstream presenting its next item. When both happen together, the stage must capture right away, and it must not capture one cycle early. The bench drives each branch with its own random probability and swaps which branch is the slow one during the run. In the last phase every side runs at full rate, so these coincidences happen often. A behavioural model based on item counts predicts every output on every cycle. It also checks that each fork toggle saw both acknowledges and that each join toggle saw both requests.

// File: rtl/fj_pkg.sv
// Shared constants for the two-phase fork/join controller.
package fj_pkg;
    // Number of branches on each side of a fork or join.
    localparam int unsigned FJ_WAYS = 2;
    // Phase of a two-phase handshake line.
    typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;
endpackage

// File: rtl/fj_celem.sv
// Clocked Muller C-element.
// Purpose: the output follows the inputs when they all agree and holds otherwise.
// Assumes: two-phase inputs that are at most one toggle apart from each other.
module fj_celem #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ins,
    output logic         q
);
    logic all_hi;
    logic all_lo;

    generate
        if (N == 1) begin : g_single
            assign all_hi = ins[0];
            assign all_lo = ~ins[0];
        end else begin : g_multi
            assign all_hi = &ins;
            assign all_lo = ~|ins;
        end
    endgenerate

    // Update the output on agreement and hold it on disagreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (all_hi) begin
            q <= 1'b1;
        end else if (all_lo) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/fj_stage.sv
// Capture stage with a two-phase latch controller.
// Purpose: hold one item and capture the next one once downstream has caught up.
// Assumes: upstream data is stable while in_req differs from phase.
module fj_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_req,
    input  logic [W-1:0] in_data,
    input  logic         out_ack,
    output fj_pkg::phase_e phase,
    output logic [W-1:0] data_q
);
    import fj_pkg::*;

    logic new_item;
    logic drained;
    logic take;

    // Detect a pending item and check that the previous one was consumed.
    always_comb begin
        new_item = in_req ^ phase;
        drained  = ~(out_ack ^ phase);
        take     = new_item & drained;
    end

    // Capture the item and move to the new phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_EVEN;
            data_q <= '0;
        end else if (take) begin
            phase  <= phase_e'(in_req);
            data_q <= in_data;
        end
    end
endmodule

// File: rtl/fj_fork.sv
// Fork controller: one source, two destinations.
// Purpose: drive the request and data to both destinations and merge their acknowledges.
// Assumes: each destination toggles its acknowledge once per request toggle.
module fj_fork #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src_req,
    input  logic [W-1:0] src_data,
    output logic         src_ack,
    output logic         dst_req,
    output logic [W-1:0] dst_data,
    input  logic [fj_pkg::FJ_WAYS-1:0] dst_ack
);
    import fj_pkg::*;

    logic   ack_merged;
    phase_e ph;

    fj_celem #(.N(FJ_WAYS)) u_ack_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .ins   (dst_ack),
        .q     (ack_merged)
    );

    fj_stage #(.W(W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (src_req),
        .in_data (src_data),
        .out_ack (ack_merged),
        .phase   (ph),
        .data_q  (dst_data)
    );

    // The stage phase serves as both the downstream request and the upstream acknowledge.
    always_comb begin
        dst_req = ph;
        src_ack = ph;
    end
endmodule

// File: rtl/fj_join.sv
// Join controller: two sources, one destination.
// Purpose: merge the source requests and concatenate their words into one item.
// Assumes: each source holds its word until the shared acknowledge matches its request.
module fj_join #(
    parameter int unsigned W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [fj_pkg::FJ_WAYS-1:0]   src_req,
    input  logic [fj_pkg::FJ_WAYS*W-1:0] src_data,
    output logic src_ack,
    output logic dst_req,
    output logic [fj_pkg::FJ_WAYS*W-1:0] dst_data,
    input  logic dst_ack
);
    import fj_pkg::*;

    localparam int unsigned JW = FJ_WAYS * W;

    logic   req_merged;
    phase_e ph;

    fj_celem #(.N(FJ_WAYS)) u_req_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .ins   (src_req),
        .q     (req_merged)
    );

    fj_stage #(.W(JW)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_req  (req_merged),
        .in_data (src_data),
        .out_ack (dst_ack),
        .phase   (ph),
        .data_q  (dst_data)
    );

    // The stage phase is the merged request and is fanned out as the source acknowledge.
    always_comb begin
        dst_req = ph;
        src_ack = ph;
    end
endmodule

// File: rtl/fj_ctrl.sv
// Top: a two-way fork and a two-way join for transition-signaled pipelines.
// Purpose: glue for non-linear bundled-data pipelines.
// Assumes: all request and acknowledge lines follow the two-phase protocol, with data bundled.
module fj_ctrl #(
    parameter int unsigned DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fk_in_req,
    input  logic [DW-1:0]   fk_in_data,
    output logic            fk_in_ack,
    output logic            fk_out_req,
    output logic [DW-1:0]   fk_out_data,
    input  logic            fk_out_ack_a,
    input  logic            fk_out_ack_b,
    input  logic            jn_in_req_a,
    input  logic [DW-1:0]   jn_in_data_a,
    input  logic            jn_in_req_b,
    input  logic [DW-1:0]   jn_in_data_b,
    output logic            jn_in_ack,
    output logic            jn_out_req,
    output logic [2*DW-1:0] jn_out_data,
    input  logic            jn_out_ack
);
    fj_fork #(.W(DW)) u_fork (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  (fk_in_req),
        .src_data (fk_in_data),
        .src_ack  (fk_in_ack),
        .dst_req  (fk_out_req),
        .dst_data (fk_out_data),
        .dst_ack  ({fk_out_ack_b, fk_out_ack_a})
    );

    fj_join #(.W(DW)) u_join (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_req  ({jn_in_req_a, jn_in_req_b}),
        .src_data ({jn_in_data_a, jn_in_data_b}),
        .src_ack  (jn_in_ack),
        .dst_req  (jn_out_req),
        .dst_data (jn_out_data),
        .dst_ack  (jn_out_ack)
    );
endmodule

// File: rtl/fj_ctrl_chk.sv
// Protocol checker for fj_ctrl, bound to the top module.
// Assumes: the environment obeys the two-phase protocol.
module fj_ctrl_chk #(
    parameter int unsigned DW = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fk_in_req,
    input logic            fk_in_ack,
    input logic            fk_out_req,
    input logic [DW-1:0]   fk_out_data,
    input logic            fk_out_ack_a,
    input logic            fk_out_ack_b,
    input logic            jn_in_req_a,
    input logic            jn_in_req_b,
    input logic            jn_out_req,
    input logic [2*DW-1:0] jn_out_data,
    input logic            jn_out_ack
);
    // R2: the fork toggles only after both destinations have acknowledged.
    a_r2_fork_both_acks: assert property (@(posedge clk) disable iff (!rst_n)
        (fk_out_req != $past(fk_out_req)) |->
            ($past(fk_out_ack_a) == $past(fk_out_req) && $past(fk_out_ack_b) == $past(fk_out_req)));

    // R4: the fork data holds between toggles.
    a_r4_fork_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fk_out_req == $past(fk_out_req)) |-> (fk_out_data == $past(fk_out_data)));

    // R5: the join toggles only after both sources have requested.
    a_r5_join_both_reqs: assert property (@(posedge clk) disable iff (!rst_n)
        (jn_out_req != $past(jn_out_req)) |->
            ($past(jn_in_req_a) != $past(jn_out_req) && $past(jn_in_req_b) != $past(jn_out_req)));

    // R8: the join data holds between toggles.
    a_r8_join_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (jn_out_req == $past(jn_out_req)) |-> (jn_out_data == $past(jn_out_data)));

    // R7: the join does not take an item while the destination still owes an acknowledge.
    a_r7_join_waits_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(jn_out_ack) != $past(jn_out_req)) |-> (jn_out_req == $past(jn_out_req)));

    // R3: the fork moves only toward the upstream request phase.
    a_r3_fork_follows_src: assert property (@(posedge clk) disable iff (!rst_n)
        (fk_in_ack != $past(fk_in_ack)) |-> (fk_in_ack == $past(fk_in_req)));
endmodule

bind fj_ctrl fj_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_fj_ctrl.sv
// Self-checking bench: count-based behavioural model compared on every cycle.
module tb_fj_ctrl;
    localparam int DW = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NITEMS = 150;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fk_in_req = 1'b0, fk_out_ack_a = 1'b0, fk_out_ack_b = 1'b0;
    logic [DW-1:0] fk_in_data = '0, jn_in_data_a = '0, jn_in_data_b = '0;
    logic jn_in_req_a = 1'b0, jn_in_req_b = 1'b0, jn_out_ack = 1'b0;
    logic fk_in_ack, fk_out_req, jn_in_ack, jn_out_req;
    logic [DW-1:0] fk_out_data;
    logic [2*DW-1:0] jn_out_data;

    fj_ctrl #(.DW(DW)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Item counts: sent by sources, taken by stages, acknowledged by destinations.
    int fs = 0, ft = 0, fm = 0, fka = 0, fkb = 0;
    int jsa = 0, jsb = 0, jt = 0, jm = 0, jk = 0;
    logic [DW-1:0] fq[$], aq[$], bq[$];

    initial begin
        int cyc = 0;
        int psrc, pa, pb;
        int nft, nfm, njt, njm, ef, ej;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(fk_out_req == 0 && fk_in_ack == 0, "R1 fork req/ack", {fk_out_req, fk_in_ack}, 0);
        chk(fk_out_data == 0, "R1 fork data", fk_out_data, 0);
        chk(jn_out_req == 0 && jn_in_ack == 0, "R1 join req/ack", {jn_out_req, jn_in_ack}, 0);
        chk(jn_out_data == 0, "R1 join data", jn_out_data, 0);
        rst_n = 1'b1;
        while (!(ft == NITEMS && fka == NITEMS && fkb == NITEMS && jt == NITEMS && jk == NITEMS)) begin
            @(negedge clk);
            cyc++;
            if (cyc > 100000) begin
                chk(1'b0, "watchdog", cyc, 0);
                break;
            end
            // Model: stages use merge states from before this edge.
            nft = (fs > ft && fm == ft) ? ft + 1 : ft;
            nfm = (fka == fkb) ? fka : fm;
            njt = (jm > jt && jk == jt) ? jt + 1 : jt;
            njm = (jsa == jsb) ? jsa : jm;
            if (nft != ft) chk(fka == ft && fkb == ft, "R2 fork took item before both acks", fka*1000 + fkb, ft);
            if (njt != jt) chk(jsa >= njt && jsb >= njt, "R5 join took item before both requests", jsa*1000 + jsb, njt);
            ft = nft; fm = nfm; jt = njt; jm = njm;
            // Compare outputs with the model.
            chk(fk_out_req == ft[0], (fka != fkb) ? "R9 fork merge" : "R3 fork req", fk_out_req, ft[0]);
            chk(fk_in_ack == ft[0], "R3 fork ack", fk_in_ack, ft[0]);
            ef = (ft == 0) ? 0 : int'(fq[ft-1]);
            chk(int'(fk_out_data) == ef, "R4 fork data", fk_out_data, ef);
            chk(jn_out_req == jt[0], (jsa != jsb) ? "R9 join merge" : "R5 join req", jn_out_req, jt[0]);
            chk(jn_in_ack == jt[0], "R7 join ack", jn_in_ack, jt[0]);
            ej = (jt == 0) ? 0 : int'({aq[jt-1], bq[jt-1]});
            chk(int'(jn_out_data) == ej, (jt == 0) ? "R8 join data" : "R6 join data", jn_out_data, ej);
            // Branch speeds per phase: A slow, then B slow, then all at full rate.
            if (cyc < 1500)      begin psrc = 60;  pa = 15;  pb = 85;  end
            else if (cyc < 3000) begin psrc = 50;  pa = 85;  pb = 15;  end
            else                 begin psrc = 100; pa = 100; pb = 100; end
            // Fork source.
            if (fk_in_ack == fs[0] && fs < NITEMS && $urandom_range(99) < psrc) begin
                fs++;
                fk_in_data = DW'($urandom);
                fq.push_back(fk_in_data);
                fk_in_req = fs[0];
            end
            // Fork destinations.
            if (fk_out_req != fka[0] && $urandom_range(99) < pa) begin fka++; fk_out_ack_a = fka[0]; end
            if (fk_out_req != fkb[0] && $urandom_range(99) < pb) begin fkb++; fk_out_ack_b = fkb[0]; end
            // Join sources.
            if (jn_in_ack == jsa[0] && jsa < NITEMS && $urandom_range(99) < pa) begin
                jsa++;
                jn_in_data_a = DW'($urandom);
                aq.push_back(jn_in_data_a);
                jn_in_req_a = jsa[0];
            end
            if (jn_in_ack == jsb[0] && jsb < NITEMS && $urandom_range(99) < pb) begin
                jsb++;
                jn_in_data_b = DW'($urandom);
                bq.push_back(jn_in_data_b);
                jn_in_req_b = jsb[0];
            end
            // Join destination.
            if (jn_out_req != jk[0] && $urandom_range(99) < psrc) begin jk++; jn_out_ack = jk[0]; end
        end
        chk(ft == NITEMS, "R3 all fork items delivered", ft, NITEMS);
        chk(jt == NITEMS, "R6 all join items delivered", jt, NITEMS);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule